// File: doc/BRIEF.md
# Two-Tier DMA Issue Scheduler

This block picks which DMA channel may issue its next bus transfer. Each channel presents a ready request and a priority flag that marks it as high or low tier. The scheduler works in rounds. In a round it serves every ready high-tier channel once, then grants exactly one ready low-tier channel, and then starts a new round with the high tier. A low-tier channel therefore always gets a turn, even when the high tier never goes idle. When the high tier has no pending work, low-tier channels are served one after another with no loss of throughput.

The grant is a one-hot vector. It is computed combinationally from the registered scheduler state and the current requests. The state advances only on a clock edge where the transfer engine raises the issue-accept strobe while a grant is shown. The priority flags change only the order in which channels issue. They have no effect on priority on the system bus. Within each tier, channels take turns in round-robin order.

Top module: `dma_issue_sched`

## Requirements
- R1: `grant` is all-zero while `rst_n` is low, and in any cycle where `chan_req` is all-zero.
- R2: The priority flags sit in a register that resets to all-low and loads `chan_hi` on every clock edge. In the first cycle after reset release every channel is therefore scheduled as low tier, and a new `chan_hi` value takes effect one cycle after it is driven.
- R3: While some channel that is requesting and marked high has not yet been granted in the current round, only high-tier channels are granted.
- R4: Once no unserved high-tier request remains, one requesting low-tier channel is granted. The acceptance of that grant closes the round, so the next grant goes to the high tier if any high-tier channel requests. If no low-tier channel requests, a new high-tier round begins in the same cycle, with no idle cycle.
- R5: High-tier grants rotate round-robin, searching upward from the channel after the last accepted high-tier grant. After reset the search starts at channel 0.
- R6: Low-tier grants rotate round-robin in the same way, with their own pointer. After reset this search also starts at channel 0.
- R7: When no high-tier channel requests, every accepted grant goes to the next requesting low-tier channel, back to back.
- R8: `grant` has at most one bit set, and only on a requesting channel. Bit i stands for channel i.
- R9: Pointers and round state change only on a clock edge where `issue_accept` is high and `grant` is non-zero. Without an accept, the grant holds while the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | NCH | Ready request per channel |
| chan_hi | input | NCH | High-tier flag per channel |
| issue_accept | input | 1 | The transfer engine takes the current grant |
| grant | output | NCH | One-hot channel grant |

## Verification
The hardest state to reach from the ports is a round that is part way through: some high-tier channels already served, a low-tier request waiting, and the priority flags changing under it. The state is not visible, and the one-cycle lag of the priority register shifts every effect by one cycle. The bench reaches this state in two ways. Directed runs hold fixed request patterns over several rounds and compare against literal grant sequences. An exhaustive sweep walks every combination of request, priority and accept for a four-channel instance, with no reset in between, so that rounds end with requests and flags in every arrangement. A bench-side model keeps its own round state and computes the expected grant for every cycle.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  // Which tier, if any, produced this cycle's grant.
  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_HI     = 2'd1,
    PICK_LO     = 2'd2,
    PICK_HI_NEW = 2'd3
  } pick_kind_e;

  localparam int unsigned TIER_HI     = 0;
  localparam int unsigned TIER_LO     = 1;
  localparam int unsigned TIER_HI_NEW = 2;
  localparam int unsigned NUM_TIERS   = 3;
endpackage

// File: rtl/dma_sched_rr.sv
module dma_sched_rr #(
  parameter int unsigned NCH = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  input  logic [IW-1:0]  last_idx,
  output logic [NCH-1:0] pick,
  output logic [IW-1:0]  pick_idx,
  output logic           found
);
  // Search upward from last_idx+1 with wrap. The lowest offset wins.
  function automatic logic [NCH-1:0] rr_onehot(input logic [NCH-1:0] m,
                                                input logic [IW-1:0]  p);
    logic [NCH-1:0] r;
    int pos;
    r = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      pos = (int'(p) + 1 + k) % NCH;
      if (m[IW'(pos)]) r = {{(NCH-1){1'b0}}, 1'b1} << pos;
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] onehot_to_idx(input logic [NCH-1:0] v);
    logic [IW-1:0] i;
    i = '0;
    for (int k = 0; k < NCH; k++) begin
      if (v[k]) i = IW'(k);
    end
    return i;
  endfunction

  always_comb begin
    pick     = rr_onehot(cand, last_idx);
    pick_idx = onehot_to_idx(pick);
    found    = |cand;
  end
endmodule

// File: rtl/dma_sched_state.sv
module dma_sched_state
  import dma_sched_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pri_in,
  input  logic           fire,
  input  pick_kind_e     kind,
  input  logic [NCH-1:0] win_gnt,
  input  logic [IW-1:0]  win_idx,
  output logic [NCH-1:0] pri_q,
  output logic [NCH-1:0] served_q,
  output logic [IW-1:0]  hi_ptr,
  output logic [IW-1:0]  lo_ptr
);
  localparam logic [IW-1:0] PTR_RESET = IW'(NCH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q    <= '0;
      served_q <= '0;
      hi_ptr   <= PTR_RESET;
      lo_ptr   <= PTR_RESET;
    end else begin
      pri_q <= pri_in;
      if (fire) begin
        unique case (kind)
          PICK_HI: begin
            served_q <= served_q | win_gnt;
            hi_ptr   <= win_idx;
          end
          PICK_LO: begin
            served_q <= '0;
            lo_ptr   <= win_idx;
          end
          PICK_HI_NEW: begin
            served_q <= win_gnt;
            hi_ptr   <= win_idx;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_issue_sched.sv
module dma_issue_sched
  import dma_sched_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_hi,
  input  logic           issue_accept,
  output logic [NCH-1:0] grant
);
  logic [NCH-1:0] pri_q;
  logic [NCH-1:0] served_q;
  logic [IW-1:0]  hi_ptr;
  logic [IW-1:0]  lo_ptr;

  logic [NCH-1:0] tier_cand [NUM_TIERS];
  logic [IW-1:0]  tier_ptr  [NUM_TIERS];
  logic [NCH-1:0] tier_pick [NUM_TIERS];
  logic [IW-1:0]  tier_idx  [NUM_TIERS];
  logic           tier_any  [NUM_TIERS];

  pick_kind_e     kind;
  logic [NCH-1:0] win_gnt;
  logic [IW-1:0]  win_idx;
  logic           fire;

  // Events brought out for the checker.
  logic           hi_pending;
  logic           lo_take;

  always_comb begin
    tier_cand[TIER_HI]     = chan_req & pri_q & ~served_q;
    tier_cand[TIER_LO]     = chan_req & ~pri_q;
    tier_cand[TIER_HI_NEW] = chan_req & pri_q;
    tier_ptr[TIER_HI]      = hi_ptr;
    tier_ptr[TIER_LO]      = lo_ptr;
    tier_ptr[TIER_HI_NEW]  = hi_ptr;
  end

  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
    dma_sched_rr #(.NCH(NCH)) u_rr (
      .cand     (tier_cand[t]),
      .last_idx (tier_ptr[t]),
      .pick     (tier_pick[t]),
      .pick_idx (tier_idx[t]),
      .found    (tier_any[t])
    );
  end

  always_comb begin
    kind    = PICK_NONE;
    win_gnt = '0;
    win_idx = '0;
    if (rst_n) begin
      if (tier_any[TIER_HI]) begin
        kind    = PICK_HI;
        win_gnt = tier_pick[TIER_HI];
        win_idx = tier_idx[TIER_HI];
      end else if (tier_any[TIER_LO]) begin
        kind    = PICK_LO;
        win_gnt = tier_pick[TIER_LO];
        win_idx = tier_idx[TIER_LO];
      end else if (tier_any[TIER_HI_NEW]) begin
        kind    = PICK_HI_NEW;
        win_gnt = tier_pick[TIER_HI_NEW];
        win_idx = tier_idx[TIER_HI_NEW];
      end
    end
  end

  assign fire       = issue_accept && (kind != PICK_NONE);
  assign grant      = win_gnt;
  assign hi_pending = tier_any[TIER_HI];
  assign lo_take    = fire && (kind == PICK_LO);

  dma_sched_state #(.NCH(NCH)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri_in   (chan_hi),
    .fire     (fire),
    .kind     (kind),
    .win_gnt  (win_gnt),
    .win_idx  (win_idx),
    .pri_q    (pri_q),
    .served_q (served_q),
    .hi_ptr   (hi_ptr),
    .lo_ptr   (lo_ptr)
  );
endmodule

// File: rtl/dma_issue_sched_chk.sv
module dma_issue_sched_chk #(
  parameter int unsigned NCH = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_req,
  input logic [NCH-1:0] chan_hi,
  input logic           issue_accept,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] pri_q,
  input logic [NCH-1:0] served_q,
  input logic [IW-1:0]  hi_ptr,
  input logic [IW-1:0]  lo_ptr,
  input logic           hi_pending,
  input logic           lo_take
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~chan_req) == '0);

  // R1
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req == '0) |-> (grant == '0));

  // R2
  pri_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pri_q == $past(chan_hi)));

  // R3
  lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_take |-> ((chan_req & pri_q & ~served_q) == '0));

  // R4
  round_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_take |=> (served_q == '0));

  // R9
  hold_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_accept |=> ($stable(served_q) && $stable(hi_ptr) && $stable(lo_ptr)));

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pending |-> ((grant & ~pri_q) == '0));
endmodule

bind dma_issue_sched dma_issue_sched_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chan_req     (chan_req),
  .chan_hi      (chan_hi),
  .issue_accept (issue_accept),
  .grant        (grant),
  .pri_q        (pri_q),
  .served_q     (served_q),
  .hi_ptr       (hi_ptr),
  .lo_ptr       (lo_ptr),
  .hi_pending   (hi_pending),
  .lo_take      (lo_take)
);

// File: tb/dma_issue_sched_bench.sv
module dma_issue_sched_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] chan_req = '0;
  logic [N-1:0] chan_hi = '0;
  logic         issue_accept = 1'b0;
  logic [N-1:0] grant;

  int n_chk = 0;
  int n_err = 0;

  // Independent model state
  int           m_hp, m_lp;
  logic [N-1:0] m_sv, m_pq;
  logic [N-1:0] last_g;

  always #2 clk = ~clk;

  dma_issue_sched #(.NCH(N)) u_dma_issue_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_req     (chan_req),
    .chan_hi      (chan_hi),
    .issue_accept (issue_accept),
    .grant        (grant)
  );

  function automatic logic [N-1:0] nxt(input logic [N-1:0] m, input int p);
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (p + k) % N;
      if (m[c]) return N'(1) << c;
    end
    return '0;
  endfunction

  function automatic int pos_of(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] h,
                     input logic a, input string tag);
    logic [N-1:0] hc, lc, ha, e;
    int kind;
    @(negedge clk);
    chan_req = r; chan_hi = h; issue_accept = a;
    #1;
    hc = r & m_pq & ~m_sv;
    lc = r & ~m_pq;
    ha = r & m_pq;
    if (hc != 0)      begin e = nxt(hc, m_hp); kind = 1; end
    else if (lc != 0) begin e = nxt(lc, m_lp); kind = 2; end
    else if (ha != 0) begin e = nxt(ha, m_hp); kind = 3; end
    else              begin e = '0; kind = 0; end
    last_g = grant;
    check(grant === e, tag, grant, e);
    @(posedge clk);
    if (a && kind != 0) begin
      case (kind)
        1: begin m_sv = m_sv | e; m_hp = pos_of(e); end
        2: begin m_sv = '0;       m_lp = pos_of(e); end
        default: begin m_sv = e;  m_hp = pos_of(e); end
      endcase
    end
    m_pq = h;
  endtask

  task automatic do_reset(input logic [N-1:0] h, input logic [N-1:0] r);
    @(negedge clk);
    rst_n = 1'b0; chan_req = r; chan_hi = h; issue_accept = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      // R1: no grant while in reset
      check(grant === '0, "R1 reset", grant, '0);
    end
    m_hp = N - 1; m_lp = N - 1; m_sv = '0; m_pq = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2: flags still all-low in the first cycle after release
    check(grant === nxt(r, N - 1), "R2 first cycle low", grant, nxt(r, N - 1));
    @(posedge clk);
    m_pq = h;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] hold_g;
    logic [N-1:0] seq_a [12];
    logic [15:0]  lfsr;

    // R2: channel 1 flagged high, yet channel 0 wins right after reset
    do_reset(4'b0010, 4'b0011);
    cyc(4'b0011, 4'b0010, 1'b0, "R2 flag applied");
    check(last_g === 4'b0010, "R2 literal", last_g, 4'b0010);

    // R1: no requests, no grant
    cyc(4'b0000, 4'b0010, 1'b1, "R1 idle");
    check(last_g === 4'b0000, "R1 literal", last_g, 4'b0000);

    // R3 R4 R5 R6: two high + two low, saturated
    seq_a = '{4'b0001, 4'b0010, 4'b0100, 4'b0001, 4'b0010, 4'b1000,
              4'b0001, 4'b0010, 4'b0100, 4'b0001, 4'b0010, 4'b1000};
    do_reset(4'b0011, 4'b1111);
    for (int i = 0; i < 12; i++) begin
      cyc(4'b1111, 4'b0011, 1'b1, "R3 R4 R5 R6 saturated");
      check(last_g === seq_a[i], "R4 round order", last_g, seq_a[i]);
    end

    // R9: no accept, grant holds
    cyc(4'b1111, 4'b0011, 1'b0, "R9 hold");
    hold_g = last_g;
    for (int i = 0; i < 4; i++) begin
      cyc(4'b1111, 4'b0011, 1'b0, "R9 hold");
      check(last_g === hold_g, "R9 stable", last_g, hold_g);
    end

    // R7: no high tier, lows back to back
    do_reset(4'b0000, 4'b1010);
    for (int i = 0; i < 4; i++) begin
      cyc(4'b1010, 4'b0000, 1'b1, "R7 lows");
      check(last_g === ((i % 2 == 0) ? 4'b0010 : 4'b1000), "R7 literal",
            last_g, (i % 2 == 0) ? 4'b0010 : 4'b1000);
    end

    // R4: only high tier requests, rounds restart with no idle cycle
    do_reset(4'b0011, 4'b0011);
    for (int i = 0; i < 6; i++) begin
      cyc(4'b0011, 4'b0011, 1'b1, "R4 new round");
      check(last_g === ((i % 2 == 0) ? 4'b0001 : 4'b0010), "R4 literal",
            last_g, (i % 2 == 0) ? 4'b0001 : 4'b0010);
    end

    // R5 R6 R8: exhaustive walk of request x priority x accept
    do_reset(4'b0000, 4'b0000);
    for (int r = 0; r < 16; r++)
      for (int h = 0; h < 16; h++)
        for (int a = 0; a < 2; a++)
          cyc(4'(r), 4'(h), 1'(a), "R5 R6 R8 sweep");

    // R3 R4: flags held per pattern over many rounds, pseudo-random requests
    lfsr = 16'hACE1;
    for (int h = 0; h < 16; h++)
      for (int i = 0; i < 24; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[3:0], 4'(h), lfsr[7] | lfsr[8], "R3 R4 held flags");
      end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule